// File: doc/BRIEF.md
# Phase-Accumulator PWM Generator with Shadowed Configuration

This block drives one pulse-width-modulated output from a single 32-bit control word. A phase accumulator of `INC_W` bits adds a programmable step every clock. The step sets the output frequency, which is `step × f_clk / 2^INC_W`. Each time the accumulator wraps past zero, a new output cycle begins. The top eight accumulator bits are compared against an inverted duty code to decide the output level.

Software writes the step and the duty code into a shadow copy. The running configuration is not changed until software also sets an update-request bit. At the next cycle boundary the hardware copies the shadow into the active settings and clears the request bit, so a change never lands in the middle of a period. While the output is disabled, every clock counts as a boundary. Turning the enable on loads the shadow into the active settings at once.

The parameter `EARLY_EN` selects whether the enable may be set while a request is still pending.

Top module: `phase_pwm`

## Requirements
- R1: The readback word holds enable at bit 31, the update-request flag at bit 30, the shadow step at bits [8+INC_W-1:8] and the shadow duty code at bits [7:0], and all other bits read zero. Reset clears all of them.
- R2: While enabled, the accumulator advances by the active step every clock. A cycle boundary is a carry out of its top bit. With step 4 and INC_W=10, a period is 256 clocks. With step 8, a period is 128 clocks. With step 0, no boundary occurs and the request flag stays set.
- R3: The output is high while the accumulator's top eight bits are strictly greater than the active duty code. Code 255 keeps the output low. With step 4, code 0 gives 255 high clocks per 256.
- R4: While enable is clear, the output is low and the accumulator is held at zero. After re-enabling with step 4 and duty code D, the first high clock is D+1 clocks later.
- R5: A write that is accepted with bit 30 set raises the request flag. At the next cycle boundary the shadow step and duty become active and the flag reads 0. Until then, the active settings do not change.
- R6: A write that arrives while the request flag is set leaves the shadow fields and the flag unchanged.
- R7: When enable goes from clear to set, the shadow fields are copied directly into the active settings and the request flag is cleared.
- R8: With EARLY_EN=0, an attempt to set the enable while a request is pending is ignored. With EARLY_EN=1, it is accepted. Clearing the enable is always accepted.
- R9: Shadow fields written without bit 30 do not change the output while the block is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 32 | Control word to write |
| rd_data | output | 32 | Readback of the control word |
| pwm_out | output | 1 | PWM output |

## Verification
The assertions assume that each write strobe lasts a single clock and that writes use only the bit positions listed in R1. They also assume that reset is applied before the first write. The stimulus writes complete words from tasks, one strobe at a time, except in the R8 scenario. There, two writes are placed on back-to-back clocks on purpose, so that the enable request meets a pending update. Every pending update that must stay pending for a long time is held with an active step of zero. Because no boundary can occur, the timing of the scenario does not depend on the accumulator phase.

// File: rtl/phase_pwm_pkg.sv
package phase_pwm_pkg;
  localparam int CW_W      = 32;
  localparam int EN_POS    = 31;
  localparam int REQ_POS   = 30;
  localparam int STEP_LSB  = 8;
  localparam int DUTY_W    = 8;

  // high phase: top byte strictly above the inverted duty code
  function automatic logic level_high(input logic [DUTY_W-1:0] top,
                                      input logic [DUTY_W-1:0] code);
    return top > code;
  endfunction
endpackage

// File: rtl/phase_pwm_regs.sv
module phase_pwm_regs
  import phase_pwm_pkg::*;
#(
  parameter int INC_W    = 10,
  parameter bit EARLY_EN = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CW_W-1:0]   wr_data,
  input  logic              cyc_start,
  output logic              en_q,
  output logic              req_q,
  output logic [INC_W-1:0]  step_sh,
  output logic [DUTY_W-1:0] duty_sh,
  output logic [INC_W-1:0]  step_act,
  output logic [DUTY_W-1:0] duty_act,
  output logic [CW_W-1:0]   rd_data
);
  logic              cfg_take;
  logic              en_d;
  logic              en_rise;
  logic              boundary;
  logic [INC_W-1:0]  step_d;
  logic [DUTY_W-1:0] duty_d;

  assign cfg_take = wr_en & ~req_q;
  assign en_d     = wr_en ? (wr_data[EN_POS] & (en_q | EARLY_EN | ~req_q)) : en_q;
  assign en_rise  = ~en_q & en_d;
  assign boundary = req_q & (cyc_start | ~en_q);
  assign step_d   = cfg_take ? wr_data[STEP_LSB +: INC_W] : step_sh;
  assign duty_d   = cfg_take ? wr_data[DUTY_W-1:0] : duty_sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q     <= 1'b0;
      req_q    <= 1'b0;
      step_sh  <= '0;
      duty_sh  <= '0;
      step_act <= '0;
      duty_act <= '0;
    end else begin
      en_q    <= en_d;
      step_sh <= step_d;
      duty_sh <= duty_d;
      if (boundary || en_rise) req_q <= 1'b0;
      else if (cfg_take)       req_q <= wr_data[REQ_POS];
      if (en_rise) begin
        step_act <= step_d;
        duty_act <= duty_d;
      end else if (boundary) begin
        step_act <= step_sh;
        duty_act <= duty_sh;
      end
    end
  end

  always_comb begin
    rd_data                      = '0;
    rd_data[EN_POS]              = en_q;
    rd_data[REQ_POS]             = req_q;
    rd_data[STEP_LSB +: INC_W]   = step_sh;
    rd_data[DUTY_W-1:0]          = duty_sh;
  end
endmodule

// File: rtl/phase_pwm_accum.sv
module phase_pwm_accum
  import phase_pwm_pkg::*;
#(
  parameter int INC_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [INC_W-1:0]  step,
  output logic [DUTY_W-1:0] top,
  output logic              wrap
);
  localparam int TOP_LSB = INC_W - DUTY_W;

  logic [INC_W-1:0] phase_q;
  logic [INC_W:0]   sum;

  assign sum  = {1'b0, phase_q} + {1'b0, step};
  assign wrap = run & sum[INC_W];
  assign top  = phase_q[TOP_LSB +: DUTY_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   phase_q <= '0;
    else if (run) phase_q <= sum[INC_W-1:0];
    else          phase_q <= '0;
  end
endmodule

// File: rtl/phase_pwm_cmp.sv
module phase_pwm_cmp
  import phase_pwm_pkg::*;
(
  input  logic              en,
  input  logic [DUTY_W-1:0] top,
  input  logic [DUTY_W-1:0] code,
  output logic              level
);
  assign level = en & level_high(top, code);
endmodule

// File: rtl/phase_pwm.sv
module phase_pwm
  import phase_pwm_pkg::*;
#(
  parameter int INC_W    = 10,
  parameter bit EARLY_EN = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  output logic [31:0] rd_data,
  output logic        pwm_out
);
  logic              en_q;
  logic              req_q;
  logic              wrap;
  logic [INC_W-1:0]  step_sh;
  logic [INC_W-1:0]  step_act;
  logic [DUTY_W-1:0] duty_sh;
  logic [DUTY_W-1:0] duty_act;
  logic [DUTY_W-1:0] top;

  phase_pwm_regs #(.INC_W(INC_W), .EARLY_EN(EARLY_EN)) regs_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .cyc_start(wrap), .en_q(en_q), .req_q(req_q),
    .step_sh(step_sh), .duty_sh(duty_sh),
    .step_act(step_act), .duty_act(duty_act), .rd_data(rd_data)
  );

  phase_pwm_accum #(.INC_W(INC_W)) accum_i (
    .clk(clk), .rst_n(rst_n), .run(en_q), .step(step_act),
    .top(top), .wrap(wrap)
  );

  phase_pwm_cmp cmp_i (
    .en(en_q), .top(top), .code(duty_act), .level(pwm_out)
  );
endmodule

// File: rtl/phase_pwm_chk.sv
module phase_pwm_chk #(
  parameter int INC_W    = 10,
  parameter bit EARLY_EN = 1'b0
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic             en,
  input logic             req,
  input logic             wrap,
  input logic             pwm_out,
  input logic [INC_W-1:0] step_sh,
  input logic [7:0]       duty_sh,
  input logic [INC_W-1:0] step_act,
  input logic [7:0]       duty_act
);
  AST_OFF_OUTPUT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !pwm_out); // R4
  AST_ZERO_STEP_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (step_act == '0) |-> !wrap); // R2
  AST_CODE_FF_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (duty_act == 8'hFF) |-> !pwm_out); // R3
  AST_COMMIT_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (en && req && wrap) |=> (!req && step_act == $past(step_sh) && duty_act == $past(duty_sh))); // R5
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (en && req && !wrap) |=> req); // R5
  AST_PENDING_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (req && wr_en) |=> ($stable(step_sh) && $stable(duty_sh))); // R6
  AST_ACTIVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !wrap) |=> ($stable(step_act) && $stable(duty_act))); // R9
  AST_LATE_ENABLE_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (!EARLY_EN && req && !en) |=> !en); // R8
endmodule

bind phase_pwm phase_pwm_chk #(.INC_W(INC_W), .EARLY_EN(EARLY_EN)) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .en(en_q), .req(req_q),
  .wrap(wrap), .pwm_out(pwm_out), .step_sh(step_sh), .duty_sh(duty_sh),
  .step_act(step_act), .duty_act(duty_act)
);

// File: tb/phase_pwm_tb_top.sv
module phase_pwm_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic [31:0] rd_e;
  logic        pwm_out;
  logic        out_e;
  int          total = 0;
  int          bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  phase_pwm #(.INC_W(10), .EARLY_EN(1'b0)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .pwm_out(pwm_out));

  phase_pwm #(.INC_W(10), .EARLY_EN(1'b1)) dut_e (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_e), .pwm_out(out_e));

  function automatic logic [31:0] word(input logic en, input logic req,
                                       input logic [9:0] step, input logic [7:0] duty);
    return {en, req, 12'b0, step, duty};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic write(input logic [31:0] w);
    wr_data = w;
    wr_en   = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic window(input int n, output int cnt);
    cnt = 0;
    for (int i = 0; i < n; i++) begin
      if (pwm_out) cnt++;
      @(negedge clk);
    end
  endtask

  task automatic wait_commit(input string req);
    int k = 0;
    while (rd_data[30] && k < 2000) begin
      @(negedge clk);
      k++;
    end
    check(req, {31'b0, rd_data[30]}, 32'd0);
  endtask

  task automatic first_high(output int n);
    n = 0;
    while (!pwm_out && n < 2000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic t_reset();
    check("R1 reset word", rd_data, 32'h0);
    check("R1 reset out", {31'b0, pwm_out}, 32'd0);
  endtask

  task automatic t_enable_load();
    int n;
    int c;
    write(word(1, 0, 10'd4, 8'd127));
    check("R1 readback", rd_data, word(1, 0, 10'd4, 8'd127));
    first_high(n);
    check("R7 first high after enable", n, 128);
    window(256, c);
    check("R3 code 127 high count", c, 128);
  endtask

  task automatic t_shadow_only();
    int c;
    write(word(1, 0, 10'd4, 8'd200));
    check("R9 shadow readback", rd_data, word(1, 0, 10'd4, 8'd200));
    window(256, c);
    check("R9 output unchanged", c, 128);
  endtask

  task automatic t_update();
    int c;
    write(word(1, 1, 10'd4, 8'd200));
    check("R5 request visible", {31'b0, rd_data[30]}, 32'd1);
    wait_commit("R5 request cleared");
    window(256, c);
    check("R5 new duty active", c, 55);
  endtask

  task automatic t_duty_ends();
    int c;
    write(word(1, 1, 10'd4, 8'd255));
    wait_commit("R3 commit 255");
    window(256, c);
    check("R3 code 255 never high", c, 0);
    write(word(1, 1, 10'd4, 8'd0));
    wait_commit("R3 commit 0");
    window(256, c);
    check("R3 code 0 high count", c, 255);
  endtask

  task automatic t_step();
    int c;
    window(1024, c);
    check("R2 step 4 window", c, 1020);
    write(word(1, 1, 10'd8, 8'd0));
    wait_commit("R2 commit step 8");
    window(1024, c);
    check("R2 step 8 window", c, 1016);
  endtask

  task automatic t_pending_ignored();
    int c;
    int n;
    write(word(1, 1, 10'd0, 8'd0));
    wait_commit("R2 commit step 0");
    window(256, c);
    check("R2 step 0 static output", {31'b0, (c == 0 || c == 256)}, 32'd1);
    write(word(1, 1, 10'd4, 8'd200));
    repeat (2000) @(negedge clk);
    check("R2 no boundary with step 0", {31'b0, rd_data[30]}, 32'd1);
    write(word(1, 1, 10'd8, 8'd10));
    check("R6 write ignored", rd_data, word(1, 1, 10'd4, 8'd200));
    write(word(0, 0, 10'd8, 8'd10));
    check("R8 clear accepted while pending", rd_data, word(0, 1, 10'd4, 8'd200));
    @(negedge clk);
    check("R4 idle commit", rd_data, word(0, 0, 10'd4, 8'd200));
    window(300, c);
    check("R4 output low when off", c, 0);
    write(word(1, 0, 10'd4, 8'd200));
    first_high(n);
    check("R4 phase restarts at zero", n, 201);
  endtask

  task automatic t_late_enable();
    write(word(0, 0, 10'd4, 8'd50));
    @(negedge clk);
    wr_data = word(0, 1, 10'd4, 8'd50);
    wr_en   = 1'b1;
    @(negedge clk);
    wr_data = word(1, 0, 10'd4, 8'd50);
    @(negedge clk);
    wr_en = 1'b0;
    check("R8 blocked enable (EARLY_EN=0)", {31'b0, rd_data[31]}, 32'd0);
    check("R8 accepted enable (EARLY_EN=1)", {31'b0, rd_e[31]}, 32'd1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_enable_load();
    t_shadow_only();
    t_update();
    t_duty_ends();
    t_step();
    t_pending_ignored();
    t_late_enable();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule